// File: doc/BRIEF.md
# GPS-Disciplined Timestamp Generator

This block produces a 96-bit capture timestamp from two inputs. The first is a 32-bit POSIX seconds value. The second is a 64-bit picosecond count inside the current second. The block receives a byte stream from a GPS receiver's binary serial protocol. It locates clock-status messages in that stream, verifies their framing and checksum, and converts the GPS week and time-of-week into POSIX seconds, including the leap-second correction.

The block also takes a pulse-per-second input. It counts how many system clocks pass between consecutive pulses and uses that count as the length of its own internal second. At every internal second boundary it either loads the freshly decoded time plus one, or advances the seconds value by one. The picosecond count restarts at the same boundary.

A helper circuit measures the cable delay. It raises a launch line, times how long the looped-back return takes, and keeps half of that time. The internal second boundary is then placed that many clocks ahead of the received pulse.

The byte input is a valid/ready stream. A byte is taken on each clock in which both valid and ready are high. Ready is low only while reset is asserted, so the sender never sees back-pressure in normal operation. The pulse, delay and timestamp pins are plain levels.

Top module: `gts_timestamp_gen`

## Requirements
- R1: A frame is the bytes 0xA0 0xA2, then a 2-byte big-endian length (bit 15 must be zero, value 1 to 1023), then the payload, then a 2-byte checksum, then 0xB0 0xB3. The hunter re-synchronises on 0xA0 0xA0 0xA2. A frame whose length is out of range is dropped.
- R2: The checksum is the 15-bit sum of all payload bytes, sent big-endian. A frame with a wrong checksum or a wrong trailer has no effect on the time.
- R3: Only payloads whose first byte is 0x07 and whose length is at least 7 are used. Payloads with any other first byte are ignored.
- R4: Payload bytes 1–2 hold the GPS week and bytes 3–6 hold the time-of-week in hundredths of a second, both big-endian. The decoded seconds are 315964800 + week·604800 + tow/100 − 15, modulo 2^32.
- R5: An accepted message sets the seconds output to the decoded value plus one at the next internal second boundary. The same boundary raises time_locked, and time_locked then stays high.
- R6: At a boundary with no newly decoded time pending, the seconds output advances by exactly one.
- R7: The picosecond output is zero in the cycle after a boundary and grows by PS_STEP (10000 by default) each clock.
- R8: drift_clks holds the number of clocks between the last two synchronised rising edges of pps_in.
- R9: The internal second lasts drift_clks clocks once drift_clks is measured, and NOMINAL_CLKS before that. Each external edge resets the phase to one_way_clks, so boundaries fall one_way_clks clocks before the detected edge. With a zero delay they fall on the detected edge itself, two clocks after pps_in rises.
- R10: A pulse on dly_start while the meter is idle raises dly_launch. The meter counts clocks until its 2-stage synchronised copy of dly_return goes high, then drops dly_launch and stores half the count (rounded down) in one_way_clks. If the return rises L clocks after the launch, the result is (L+2)/2.
- R11: gps_ready is low in reset and high from the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gps_byte | input | 8 | Received serial byte |
| gps_valid | input | 1 | gps_byte is valid |
| gps_ready | output | 1 | Block accepts a byte this cycle |
| pps_in | input | 1 | Pulse-per-second from the receiver, asynchronous |
| dly_start | input | 1 | Starts one delay measurement |
| dly_return | input | 1 | Looped-back launch line, asynchronous |
| dly_launch | output | 1 | Launch line of the delay measurement |
| ts_seconds | output | 32 | POSIX seconds |
| ts_picos | output | 64 | Picoseconds inside the current second |
| drift_clks | output | CNT_W | Clocks between the last two PPS edges |
| one_way_clks | output | DLY_W | Measured one-way delay in clocks |
| time_locked | output | 1 | A decoded time has been applied |

## Verification
The bench goes after the cases that catch a careless frame hunter and time loader:
- A repeated sync byte before 0xA2. A hunter that restarts on it would lose the frame.
- An oversize length. A parser that accepts it would consume the bytes that follow as payload.
- A corrupted checksum, a corrupted trailer and a foreign message ID. Any of these, if let through, would corrupt the seconds value.
- Random weeks and times-of-week. A wrong byte order, a missing leap correction or a missing "+1" shows up as an offset in the loaded seconds.

It also checks four timing points:
- The picosecond restart cycle.
- The drift value after the PPS period changes.
- The shift of the boundary once a delay is measured.
- The (L+2)/2 rounding of random loopback delays. A meter that omits the synchronizer latency or the halving would report a different value.

// File: rtl/gts_pkg.sv
package gts_pkg;
  localparam logic [7:0] SYNC_A     = 8'hA0;
  localparam logic [7:0] SYNC_B     = 8'hA2;
  localparam logic [7:0] TAIL_A     = 8'hB0;
  localparam logic [7:0] TAIL_B     = 8'hB3;
  localparam logic [7:0] CLK_STAT_ID = 8'h07;
  localparam logic [31:0] SECS_PER_WEEK = 32'd604800;
  localparam logic [31:0] GPS_EPOCH_POSIX = 32'd315964800;

  typedef enum logic [3:0] {
    PS_HUNT0, PS_HUNT1, PS_LEN_HI, PS_LEN_LO, PS_BODY,
    PS_CK_HI, PS_CK_LO, PS_TAIL0, PS_TAIL1
  } parse_st_t;

  typedef enum logic {DM_IDLE, DM_MEAS} dly_st_t;

  typedef struct packed {
    logic [15:0] week;
    logic [31:0] tow_cs;
  } gps_time_t;
endpackage

// File: rtl/gts_frame_parser.sv
module gts_frame_parser
  import gts_pkg::*;
#(
  parameter int unsigned MAX_LEN = 1023
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_i,
  input  logic       take_i,
  output gps_time_t  time_o,
  output logic       done_o
);
  localparam int unsigned LEN_W = 15;

  parse_st_t        st;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] idx;
  logic [14:0]      sum;
  logic [6:0]       ck_hi;
  logic             ck_ok;
  logic [7:0]       msg_id;
  logic [15:0]      wk_acc;
  logic [31:0]      tow_acc;
  logic [LEN_W-1:0] new_len;

  assign new_len = {len[14:8], byte_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PS_HUNT0;
      len     <= '0;
      idx     <= '0;
      sum     <= '0;
      ck_hi   <= '0;
      ck_ok   <= 1'b0;
      msg_id  <= '0;
      wk_acc  <= '0;
      tow_acc <= '0;
      time_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take_i) begin
        unique case (st)
          PS_HUNT0: if (byte_i == SYNC_A) st <= PS_HUNT1;
          PS_HUNT1: begin
            if (byte_i == SYNC_B) st <= PS_LEN_HI;
            else if (byte_i != SYNC_A) st <= PS_HUNT0;
          end
          PS_LEN_HI: begin
            len[14:8] <= byte_i[6:0];
            st <= byte_i[7] ? PS_HUNT0 : PS_LEN_LO;
          end
          PS_LEN_LO: begin
            if (new_len == '0 || new_len > LEN_W'(MAX_LEN)) begin
              st <= PS_HUNT0;
            end else begin
              len <= new_len;
              idx <= '0;
              sum <= '0;
              st  <= PS_BODY;
            end
          end
          PS_BODY: begin
            sum <= sum + 15'(byte_i);
            case (idx)
              15'd0: msg_id         <= byte_i;
              15'd1: wk_acc[15:8]   <= byte_i;
              15'd2: wk_acc[7:0]    <= byte_i;
              15'd3: tow_acc[31:24] <= byte_i;
              15'd4: tow_acc[23:16] <= byte_i;
              15'd5: tow_acc[15:8]  <= byte_i;
              15'd6: tow_acc[7:0]   <= byte_i;
              default: ;
            endcase
            idx <= idx + 1'b1;
            if (idx == len - 1'b1) st <= PS_CK_HI;
          end
          PS_CK_HI: begin
            ck_hi <= byte_i[6:0];
            st <= byte_i[7] ? PS_HUNT0 : PS_CK_LO;
          end
          PS_CK_LO: begin
            ck_ok <= ({ck_hi, byte_i} == sum);
            st    <= PS_TAIL0;
          end
          PS_TAIL0: begin
            if (byte_i == TAIL_A) st <= PS_TAIL1;
            else if (byte_i == SYNC_A) st <= PS_HUNT1;
            else st <= PS_HUNT0;
          end
          PS_TAIL1: begin
            if (byte_i == TAIL_B && ck_ok && msg_id == CLK_STAT_ID && len >= 15'd7) begin
              done_o <= 1'b1;
              time_o <= '{week: wk_acc, tow_cs: tow_acc};
            end
            st <= (byte_i == SYNC_A) ? PS_HUNT1 : PS_HUNT0;
          end
          default: st <= PS_HUNT0;
        endcase
      end
    end
  end

  // R1: payload is only walked with a legal length
  p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_BODY) |-> (len != '0 && len <= LEN_W'(MAX_LEN)));
  // R3: an accepted message is a single-cycle event
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/gts_time_conv.sv
module gts_time_conv
  import gts_pkg::*;
#(
  parameter int unsigned LEAP_SECS = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  gps_time_t   time_i,
  input  logic        vld_i,
  output logic [31:0] posix_o,
  output logic        vld_o
);
  logic [31:0] wk_secs;
  logic [31:0] tow_secs;
  logic [31:0] posix_c;

  always_comb begin
    wk_secs  = 32'(time_i.week) * SECS_PER_WEEK;
    tow_secs = time_i.tow_cs / 32'd100;
    posix_c  = GPS_EPOCH_POSIX + wk_secs + tow_secs - 32'(LEAP_SECS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posix_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) posix_o <= posix_c;
    end
  end

  // R4: converted value appears exactly one cycle after the parser result
  p_conv_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);
endmodule

// File: rtl/gts_delay_meter.sv
module gts_delay_meter
  import gts_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             return_i,
  output logic             launch_o,
  output logic [DLY_W-1:0] one_way_o
);
  dly_st_t          st;
  logic [DLY_W-1:0] timer;
  logic             ret_m;
  logic             ret_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_m <= 1'b0;
      ret_s <= 1'b0;
    end else begin
      ret_m <= return_i;
      ret_s <= ret_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= DM_IDLE;
      timer     <= '0;
      launch_o  <= 1'b0;
      one_way_o <= '0;
    end else begin
      unique case (st)
        DM_IDLE: if (start_i) begin
          launch_o <= 1'b1;
          timer    <= '0;
          st       <= DM_MEAS;
        end
        DM_MEAS: begin
          if (ret_s) begin
            one_way_o <= timer >> 1;
            launch_o  <= 1'b0;
            st        <= DM_IDLE;
          end else if (timer != '1) begin
            timer <= timer + 1'b1;
          end
        end
        default: st <= DM_IDLE;
      endcase
    end
  end

  // R10: the launch line falls once the return is seen
  p_launch_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DM_MEAS && ret_s) |=> (!launch_o && st == DM_IDLE));
  // R10: launch is only ever high while measuring
  p_launch_meas_r10: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |-> (st == DM_MEAS));
endmodule

// File: rtl/gts_clock_core.sv
module gts_clock_core #(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned NOMINAL_CLKS = 100_000_000,
  parameter int unsigned PS_STEP      = 10000,
  parameter int unsigned DLY_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_i,
  input  logic             load_vld_i,
  input  logic [31:0]      load_sec_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [31:0]      sec_o,
  output logic [63:0]      ps_o,
  output logic [CNT_W-1:0] drift_o,
  output logic             locked_o
);
  logic             pps_m, pps_s, pps_d;
  logic             ext_edge;
  logic             seen_edge;
  logic             drift_vld;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] period;
  logic             tick;
  logic             pending;
  logic [31:0]      pend_sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pps_m <= 1'b0;
      pps_s <= 1'b0;
      pps_d <= 1'b0;
    end else begin
      pps_m <= pps_i;
      pps_s <= pps_m;
      pps_d <= pps_s;
    end
  end

  assign ext_edge = pps_s & ~pps_d;
  assign period   = drift_vld ? drift_o : CNT_W'(NOMINAL_CLKS);
  assign tick     = (ph >= period - 1'b1);

  // drift measurement
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      seen_edge <= 1'b0;
      drift_vld <= 1'b0;
      drift_o   <= '0;
    end else if (ext_edge) begin
      cnt       <= CNT_W'(1);
      seen_edge <= 1'b1;
      if (seen_edge) begin
        drift_o   <= cnt;
        drift_vld <= 1'b1;
      end
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  // internal second phase
  always_ff @(posedge clk) begin
    if (!rst_n)        ph <= '0;
    else if (ext_edge) ph <= CNT_W'(delay_i);
    else if (tick)     ph <= '0;
    else               ph <= ph + 1'b1;
  end

  // seconds and sub-second counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      pend_sec <= '0;
      sec_o    <= '0;
      ps_o     <= '0;
      locked_o <= 1'b0;
    end else begin
      if (load_vld_i) begin
        pending  <= 1'b1;
        pend_sec <= load_sec_i;
      end else if (tick) begin
        pending <= 1'b0;
      end
      if (tick) begin
        ps_o <= '0;
        if (pending) begin
          sec_o    <= pend_sec + 32'd1;
          locked_o <= 1'b1;
        end else begin
          sec_o <= sec_o + 32'd1;
        end
      end else begin
        ps_o <= ps_o + 64'(PS_STEP);
      end
    end
  end

  // R6: free-running advance by one at a boundary with nothing pending
  p_sec_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pending) |=> (sec_o == $past(sec_o) + 32'd1));
  // R7: sub-second count restarts at a boundary
  p_ps_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ps_o == '0));
  // R5: lock never drops once gained
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);
  // R8: drift captures the interval counter at an edge
  p_drift_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_edge && seen_edge) |=> (drift_o == $past(cnt)));
endmodule

// File: rtl/gts_timestamp_gen.sv
module gts_timestamp_gen
  import gts_pkg::*;
#(
  parameter int unsigned MAX_LEN      = 1023,
  parameter int unsigned LEAP_SECS    = 15,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned NOMINAL_CLKS = 100_000_000,
  parameter int unsigned PS_STEP      = 10000,
  parameter int unsigned DLY_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       gps_byte,
  input  logic             gps_valid,
  output logic             gps_ready,
  input  logic             pps_in,
  input  logic             dly_start,
  input  logic             dly_return,
  output logic             dly_launch,
  output logic [31:0]      ts_seconds,
  output logic [63:0]      ts_picos,
  output logic [CNT_W-1:0] drift_clks,
  output logic [DLY_W-1:0] one_way_clks,
  output logic             time_locked
);
  gps_time_t   gtime;
  logic        gdone;
  logic [31:0] posix;
  logic        posix_vld;
  logic        take;

  always_ff @(posedge clk) begin
    if (!rst_n) gps_ready <= 1'b0;
    else        gps_ready <= 1'b1;
  end

  assign take = gps_valid & gps_ready;

  gts_frame_parser #(.MAX_LEN(MAX_LEN)) u_parser (
    .clk(clk), .rst_n(rst_n), .byte_i(gps_byte), .take_i(take),
    .time_o(gtime), .done_o(gdone)
  );

  gts_time_conv #(.LEAP_SECS(LEAP_SECS)) u_conv (
    .clk(clk), .rst_n(rst_n), .time_i(gtime), .vld_i(gdone),
    .posix_o(posix), .vld_o(posix_vld)
  );

  gts_delay_meter #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .start_i(dly_start), .return_i(dly_return),
    .launch_o(dly_launch), .one_way_o(one_way_clks)
  );

  gts_clock_core #(
    .CNT_W(CNT_W), .NOMINAL_CLKS(NOMINAL_CLKS), .PS_STEP(PS_STEP), .DLY_W(DLY_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_in), .load_vld_i(posix_vld),
    .load_sec_i(posix), .delay_i(one_way_clks), .sec_o(ts_seconds),
    .ps_o(ts_picos), .drift_o(drift_clks), .locked_o(time_locked)
  );
endmodule

// File: tb/gts_timestamp_gen_bench.sv
module gts_timestamp_gen_bench;
  localparam int unsigned NOM   = 1200;
  localparam int unsigned STEP  = 10000;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned DLY_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] gps_byte = '0;
  logic gps_valid = 1'b0;
  logic gps_ready;
  logic pps_in = 1'b0;
  logic dly_start = 1'b0;
  logic dly_return = 1'b0;
  logic dly_launch;
  logic [31:0] ts_seconds;
  logic [63:0] ts_picos;
  logic [CNT_W-1:0] drift_clks;
  logic [DLY_W-1:0] one_way_clks;
  logic time_locked;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit pps_en = 1'b0;
  int pps_period = 1000;
  int pcnt = 0;

  always #5 clk = ~clk;

  gts_timestamp_gen #(.NOMINAL_CLKS(NOM), .PS_STEP(STEP), .CNT_W(CNT_W), .DLY_W(DLY_W))
  u_gts_timestamp_gen (
    .clk(clk), .rst_n(rst_n), .gps_byte(gps_byte), .gps_valid(gps_valid),
    .gps_ready(gps_ready), .pps_in(pps_in), .dly_start(dly_start),
    .dly_return(dly_return), .dly_launch(dly_launch), .ts_seconds(ts_seconds),
    .ts_picos(ts_picos), .drift_clks(drift_clks), .one_way_clks(one_way_clks),
    .time_locked(time_locked)
  );

  always @(negedge clk) begin
    if (pps_en) begin
      if (pcnt >= pps_period - 1) begin
        pcnt = 0;
        pps_in = 1'b1;
      end else begin
        pcnt = pcnt + 1;
      end
      if (pcnt == 10) pps_in = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] to_posix(input logic [15:0] wk, input logic [31:0] tw);
    logic [63:0] v;
    v = 64'd315964800 + 64'(wk) * 64'd604800 + 64'(tw / 100) - 64'd15;
    return v[31:0];
  endfunction

  task automatic wait_pps();
    @(posedge pps_in);
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    gps_byte = b;
    gps_valid = 1'b1;
    @(posedge clk);
    while (!gps_ready) @(posedge clk);
    @(negedge clk);
    gps_valid = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  // kind: 0 good, 1 bad checksum, 2 bad trailer, 3 foreign id, 4 resync prefix, 5 oversize length
  task automatic send_frame(input int kind, input logic [15:0] wk, input logic [31:0] tw);
    logic [7:0] pl [9];
    logic [14:0] sum;
    pl[0] = (kind == 3) ? 8'h02 : 8'h07;
    pl[1] = wk[15:8];   pl[2] = wk[7:0];
    pl[3] = tw[31:24];  pl[4] = tw[23:16]; pl[5] = tw[15:8]; pl[6] = tw[7:0];
    pl[7] = 8'h55;      pl[8] = 8'h3C;
    sum = '0;
    for (int i = 0; i < 9; i++) sum = sum + 15'(pl[i]);
    if (kind == 1) sum = sum ^ 15'd1;
    if (kind == 4) begin
      put_byte(8'h13);
      put_byte(8'hA0);
    end
    put_byte(8'hA0);
    put_byte(8'hA2);
    if (kind == 5) begin
      put_byte(8'h04);
      put_byte(8'h00);
      for (int i = 0; i < 6; i++) put_byte(8'h11);
    end else begin
      put_byte(8'h00);
      put_byte(8'd9);
      for (int i = 0; i < 9; i++) put_byte(pl[i]);
      put_byte({1'b0, sum[14:8]});
      put_byte(sum[7:0]);
    end
    put_byte(8'hB0);
    put_byte((kind == 2) ? 8'hB2 : 8'hB3);
  endtask

  task automatic msg_case(input int kind, input logic [15:0] wk, input logic [31:0] tw, input string req);
    logic [31:0] sec0;
    logic [31:0] exp;
    wait_pps();
    repeat (200) @(posedge clk);
    @(negedge clk);
    sec0 = ts_seconds;
    send_frame(kind, wk, tw);
    exp = (kind == 0 || kind == 4) ? to_posix(wk, tw) + 32'd1 : sec0 + 32'd1;
    wait_pps();
    repeat (500) @(posedge clk);
    @(negedge clk);
    chk(ts_seconds == exp, req, ts_seconds, exp);
  endtask

  task automatic delay_case(input int l);
    int unsigned exp;
    @(negedge clk);
    dly_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dly_start = 1'b0;
    chk(dly_launch == 1'b1, "R10 launch high", dly_launch, 1);
    repeat (l) @(posedge clk);
    @(negedge clk);
    dly_return = 1'b1;
    repeat (l + 8) @(negedge clk);
    exp = (l + 2) / 2;
    chk(one_way_clks == DLY_W'(exp), "R10 one-way value", one_way_clks, exp);
    chk(dly_launch == 1'b0, "R10 launch dropped", dly_launch, 0);
    dly_return = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] s0;
    logic [63:0] p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(gps_ready == 1'b0, "R11 ready in reset", gps_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(gps_ready == 1'b1, "R11 ready after reset", gps_ready, 1);
    chk(ts_seconds == 0, "R6 reset seconds", ts_seconds, 0);
    chk(time_locked == 0, "R5 reset lock", time_locked, 0);
    chk(drift_clks == 0, "R8 reset drift", drift_clks, 0);
    chk(dly_launch == 0, "R10 reset launch", dly_launch, 0);

    pps_period = 1000;
    pps_en = 1'b1;
    repeat (4) wait_pps();
    repeat (20) @(negedge clk);
    chk(drift_clks == 1000, "R8 drift 1000", drift_clks, 1000);

    // R7 / R9: boundary on detected edge, picosecond restart
    wait_pps();
    repeat (5) @(posedge clk);
    @(negedge clk);
    p0 = ts_picos;
    chk(ts_picos == 64'(2 * STEP), "R7 R9 ps after boundary", ts_picos, 2 * STEP);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(ts_picos == p0 + 64'(100 * STEP), "R7 ps step", ts_picos, p0 + 100 * STEP);

    // R6 free running
    wait_pps();
    repeat (500) @(negedge clk);
    s0 = ts_seconds;
    wait_pps();
    repeat (500) @(negedge clk);
    chk(ts_seconds == s0 + 1, "R6 free run", ts_seconds, s0 + 1);

    msg_case(0, 16'd2150, 32'd34567899, "R4 R5 good frame");
    chk(time_locked == 1'b1, "R5 locked", time_locked, 1);
    msg_case(1, 16'd1000, 32'd100, "R2 bad checksum ignored");
    msg_case(2, 16'd1001, 32'd200, "R2 bad trailer ignored");
    msg_case(3, 16'd1002, 32'd300, "R3 foreign id ignored");
    msg_case(5, 16'd1003, 32'd400, "R1 oversize length ignored");
    msg_case(4, 16'd1999, 32'd60479999, "R1 resync A0 A0 A2");
    for (int i = 0; i < 5; i++) begin
      logic [15:0] wk;
      logic [31:0] tw;
      wk = 16'(1500 + $urandom % 900);
      tw = $urandom % 60480000;
      msg_case(0, wk, tw, "R4 random conversion");
    end

    // R10 delay measurement, then R9 phase offset
    for (int i = 0; i < 3; i++) delay_case(3 + int'($urandom % 30));
    delay_case(10);
    repeat (3) wait_pps();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(ts_picos == 64'((2 + 6) * STEP), "R9 boundary shifted by delay", ts_picos, (2 + 6) * STEP);

    // R8 drift follows period changes
    pps_period = 950;
    repeat (3) wait_pps();
    repeat (20) @(negedge clk);
    chk(drift_clks == 950, "R8 drift 950", drift_clks, 950);
    pps_period = 900 + int'($urandom % 200);
    repeat (3) wait_pps();
    repeat (20) @(negedge clk);
    chk(drift_clks == CNT_W'(pps_period), "R8 drift random", drift_clks, pps_period);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule